// File: doc/BRIEF.md
# Receive Length-Field Pad Stripper

This block sits in an Ethernet receive path between the MAC deframer and the receive buffer. It takes a byte stream with start and end markers. It reads the 16-bit Length/Type field of each frame. When stripping is enabled and the field holds a length, it removes every data byte past the declared length and keeps the four trailing CRC bytes. When a frame ends, the block reports how many bytes it passed on.

The position of the CRC is known only when the end marker arrives. For this reason the stream runs through a four-byte delay line. Once the last byte is in, the four bytes still held are the CRC. They are drained on the four cycles that follow. The strip-enable input is captured with the first byte of each frame, so a change in the middle of a frame takes effect only from the next one.

Top module: `rx_len_stripper`

## Requirements
- R1: When the captured enable is set, the field is a length L (1 to 1500), and 14+L is less than the frame size minus 4, only bytes 0 to 13+L are output from the data part. The discarded bytes are those from index 14+L up to the CRC.
- R2: The last 4 input bytes of every frame are always output, unchanged and in order, as the final 4 output bytes. The last of them carries out_eof.
- R3: The field is read big-endian, with byte 12 as the high byte and byte 13 as the low byte, counting from byte 0 at in_sof. The values 0, 1501 to 1535 and 1536 or more cause no stripping.
- R4: With the captured enable clear, the output frame equals the input frame byte for byte.
- R5: After reset, out_valid, out_eof and len_done are low, and the captured enable is clear.
- R6: cfg_strip_en is sampled on the byte that carries in_sof. A change later in the same frame has no effect on that frame.
- R7: If 14+L is greater than or equal to the frame size minus 4, nothing is stripped.
- R8: len_done pulses exactly once per frame, in the same cycle as out_eof. len_bytes then equals the number of bytes output for that frame, CRC included.
- R9: out_sof is high on the first output byte of a frame and on no other byte.
- R10: out_eof appears on the fourth cycle after the cycle in which in_eof is accepted. Each data byte is output one cycle after the fourth byte that follows it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strip_en | input | 1 | Strip enable, sampled at frame start |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |
| out_data | output | 8 | Output byte |
| len_done | output | 1 | Frame length report strobe |
| len_bytes | output | 16 | Bytes output for the frame |

## Verification
The assertions assume that no input byte arrives during the four drain cycles after an end marker. They also assume that each frame is at least 18 bytes long and has a single start marker on its first byte. Every bench frame is 18 bytes or longer and is followed by at least eight idle cycles. One scenario inserts idle gaps inside a frame, and those gaps never fall inside the drain window.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int LEN_W     = 16;
    localparam int HDR_BYTES = 14;
    localparam int CRC_BYTES = 4;
    localparam int MAX_LEN   = 1500;
endpackage

// File: rtl/rxs_hdr_parse.sv
module rxs_hdr_parse #(
    parameter int LEN_W     = rxs_pkg::LEN_W,
    parameter int HDR_BYTES = rxs_pkg::HDR_BYTES,
    parameter int MAX_LEN   = rxs_pkg::MAX_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             sof,
    input  logic [7:0]       data,
    input  logic             cfg_en,
    output logic             strip_o,
    output logic [LEN_W-1:0] limit_o
);
    localparam int HI_POS = HDR_BYTES - 2;
    localparam int LO_POS = HDR_BYTES - 1;
    localparam logic [LEN_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic [7:0]       hi;
        logic             en;
        logic             strip;
        logic [LEN_W-1:0] limit;
    } hdr_t;

    hdr_t s_d, s_q;
    logic [LEN_W-1:0] cur_idx;
    logic [LEN_W-1:0] field;

    always_comb begin
        s_d     = s_q;
        cur_idx = sof ? '0 : s_q.idx;
        field   = {s_q.hi, data};
        if (push) begin
            if (sof) begin
                s_d.en    = cfg_en;
                s_d.strip = 1'b0;
            end
            if (cur_idx != IDX_MAX) s_d.idx = cur_idx + 1'b1;
            if (cur_idx == LEN_W'(HI_POS)) s_d.hi = data;
            if (cur_idx == LEN_W'(LO_POS)) begin
                s_d.strip = s_d.en && (field != '0) && (field <= LEN_W'(MAX_LEN));
                s_d.limit = field + LEN_W'(HDR_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strip_o = s_q.strip;
    assign limit_o = s_q.limit;

    a_r6_en_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && sof) |=> $stable(s_q.en));
    a_r3_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.strip |-> (s_q.limit > LEN_W'(HDR_BYTES)) && (s_q.limit <= LEN_W'(HDR_BYTES + MAX_LEN)));
endmodule

// File: rtl/rxs_tail_delay.sv
module rxs_tail_delay #(
    parameter int DEPTH = rxs_pkg::CRC_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       drain,
    input  logic [7:0] din,
    output logic       full_o,
    output logic [7:0] dout
);
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] sr;
        logic [FW-1:0]         fill;
    } tail_t;

    tail_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.sr = {s_q.sr[DEPTH-2:0], din};
            if (s_q.fill != FW'(DEPTH)) s_d.fill = s_q.fill + 1'b1;
        end else if (drain) begin
            s_d.sr = {s_q.sr[DEPTH-2:0], 8'h00};
            if (s_q.fill != '0) s_d.fill = s_q.fill - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full_o = (s_q.fill == FW'(DEPTH));
    assign dout   = s_q.sr[DEPTH-1];

    a_r2_drain_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> (s_q.fill != '0));
    a_r10_no_push_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> !push);
endmodule

// File: rtl/rx_len_stripper.sv
module rx_len_stripper #(
    parameter int HDR_BYTES = rxs_pkg::HDR_BYTES,
    parameter int CRC_BYTES = rxs_pkg::CRC_BYTES,
    parameter int MAX_LEN   = rxs_pkg::MAX_LEN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_strip_en,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic                     in_eof,
    input  logic [7:0]               in_data,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic                     out_eof,
    output logic [7:0]               out_data,
    output logic                     len_done,
    output logic [rxs_pkg::LEN_W-1:0] len_bytes
);
    localparam int LEN_W = rxs_pkg::LEN_W;
    localparam int LW    = $clog2(CRC_BYTES + 1);

    typedef struct packed {
        logic             flush;
        logic [LW-1:0]    left;
        logic [LEN_W-1:0] didx;
        logic [LEN_W-1:0] cnt;
        logic             first;
        logic             ov;
        logic             osof;
        logic             oeof;
        logic [7:0]       odata;
        logic             done;
        logic [LEN_W-1:0] len;
    } top_t;

    top_t s_d, s_q;
    logic push, full, strip;
    logic [7:0] tail_byte;
    logic [LEN_W-1:0] limit;
    logic keep;

    assign push = in_valid;

    rxs_hdr_parse #(
        .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES), .MAX_LEN(MAX_LEN)
    ) u_hdr (
        .clk(clk), .rst_n(rst_n), .push(push), .sof(in_sof), .data(in_data),
        .cfg_en(cfg_strip_en), .strip_o(strip), .limit_o(limit)
    );

    rxs_tail_delay #(.DEPTH(CRC_BYTES)) u_tail (
        .clk(clk), .rst_n(rst_n), .push(push), .drain(s_q.flush),
        .din(in_data), .full_o(full), .dout(tail_byte)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ov   = 1'b0;
        s_d.osof = 1'b0;
        s_d.oeof = 1'b0;
        s_d.done = 1'b0;
        keep     = !strip || (s_q.didx < limit);
        if (push && in_sof) begin
            s_d.didx  = '0;
            s_d.cnt   = '0;
            s_d.first = 1'b1;
        end
        if (push && full) begin
            s_d.didx = s_q.didx + 1'b1;
            if (keep) begin
                s_d.ov    = 1'b1;
                s_d.odata = tail_byte;
                s_d.osof  = s_q.first;
                s_d.first = 1'b0;
                s_d.cnt   = s_d.cnt + 1'b1;
            end
        end
        if (push && in_eof) begin
            s_d.flush = 1'b1;
            s_d.left  = LW'(CRC_BYTES);
        end
        if (s_q.flush) begin
            s_d.ov    = 1'b1;
            s_d.odata = tail_byte;
            s_d.osof  = s_q.first;
            s_d.first = 1'b0;
            s_d.cnt   = s_q.cnt + 1'b1;
            s_d.left  = s_q.left - 1'b1;
            if (s_q.left == LW'(1)) begin
                s_d.flush = 1'b0;
                s_d.oeof  = 1'b1;
                s_d.done  = 1'b1;
                s_d.len   = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_sof   = s_q.osof;
    assign out_eof   = s_q.oeof;
    assign out_data  = s_q.odata;
    assign len_done  = s_q.done;
    assign len_bytes = s_q.len;

    a_r8_done_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
        len_done |-> (out_eof && out_valid));
    a_r9_sof_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
    a_r2_flush_output: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flush |=> out_valid);
    a_r10_quiet_input: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flush |-> !in_valid);
    a_r8_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        len_done |-> (len_bytes >= LEN_W'(CRC_BYTES)));
endmodule

// File: tb/tb_rx_len_stripper.sv
`timescale 1ns/1ps
module tb_rx_len_stripper;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_strip_en = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_valid, out_sof, out_eof, len_done;
    logic [7:0] out_data;
    logic [15:0] len_bytes;

    always #2.5 clk = ~clk;

    rx_len_stripper dut (
        .clk(clk), .rst_n(rst_n), .cfg_strip_en(cfg_strip_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
        .len_done(len_done), .len_bytes(len_bytes)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] got[$];
    int sof_pos[$];
    int eof_pos[$];
    int eof_cyc, done_cnt, done_len, in_eof_cyc;

    always @(negedge clk) begin
        if (out_valid) begin
            if (out_sof) sof_pos.push_back(got.size());
            if (out_eof) begin eof_pos.push_back(got.size()); eof_cyc = cyc; end
            got.push_back(out_data);
        end
        if (len_done) begin done_cnt++; done_len = len_bytes; end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one frame; en_flip_at >= 0 changes cfg_strip_en to en_after at that byte.
    task automatic run_case(input string req, input int lfield, input int n, input bit en,
                            input bit gaps, input int en_flip_at, input bit en_after,
                            input bit en_eff);
        logic [7:0] fr[];
        logic [7:0] exp[$];
        int keep_n;
        fr = new[n];
        for (int i = 0; i < n; i++) fr[i] = 8'((i * 37 + n) ^ 8'h5A);
        fr[12] = lfield[15:8];
        fr[13] = lfield[7:0];
        keep_n = n - 4;
        if (en_eff && lfield > 0 && lfield <= 1500 && (14 + lfield) < n - 4) keep_n = 14 + lfield;
        for (int i = 0; i < keep_n; i++) exp.push_back(fr[i]);
        for (int i = n - 4; i < n; i++) exp.push_back(fr[i]);
        got.delete(); sof_pos.delete(); eof_pos.delete();
        done_cnt = 0; done_len = -1; eof_cyc = -1;
        @(negedge clk);
        cfg_strip_en = en;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 5 == 3)) begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                @(negedge clk);
            end
            if (i == en_flip_at) cfg_strip_en = en_after;
            in_valid = 1'b1;
            in_sof = (i == 0);
            in_eof = (i == n - 1);
            in_data = fr[i];
            if (i == n - 1) in_eof_cyc = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (10) @(negedge clk);
        begin
            bit same;
            same = (got.size() == exp.size());
            if (same) for (int i = 0; i < exp.size(); i++) if (got[i] !== exp[i]) same = 0;
            chk(got.size() == exp.size(), req, "output size", got.size(), exp.size());
            chk(same, req, "output bytes match", same, 1);
            if (got.size() >= 4)
                chk(got[got.size()-1] === fr[n-1] && got[got.size()-4] === fr[n-4],
                    "R2", "crc bytes kept", got[got.size()-1], fr[n-1]);
            chk(sof_pos.size() == 1 && sof_pos[0] == 0, "R9", "sof once at first",
                sof_pos.size(), 1);
            chk(eof_pos.size() == 1 && eof_pos[0] == exp.size() - 1, "R2", "eof on last",
                eof_pos.size(), 1);
            chk(done_cnt == 1 && done_len == exp.size(), "R8", "length report",
                done_len, exp.size());
            chk(eof_cyc == in_eof_cyc + 5, "R10", "eof latency", eof_cyc - in_eof_cyc, 5);
        end
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0 && out_eof === 1'b0, "R5", "outputs idle after reset",
            out_valid, 0);
        chk(len_done === 1'b0, "R5", "no length strobe after reset", len_done, 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        run_case("R4", 10, 64, 0, 0, -1, 0, 0);        // disabled: unchanged
        run_case("R1", 10, 64, 1, 0, -1, 1, 1);        // stripped to 28
        run_case("R1", 20, 80, 1, 1, -1, 1, 1);        // with idle gaps
        run_case("R3", 16'h0800, 64, 1, 0, -1, 1, 1);  // type value
        run_case("R3", 0, 64, 1, 0, -1, 1, 1);         // zero
        run_case("R3", 1501, 64, 1, 0, -1, 1, 1);      // undefined range
        run_case("R3", 1535, 64, 1, 0, -1, 1, 1);
        run_case("R3", 1, 40, 1, 0, -1, 1, 1);         // smallest length
        run_case("R7", 46, 64, 1, 0, -1, 1, 1);        // exact fit
        run_case("R7", 100, 64, 1, 0, -1, 1, 1);       // longer than data
        run_case("R6", 10, 64, 1, 0, 5, 0, 1);         // disable mid-frame ignored
        run_case("R6", 10, 64, 0, 0, 5, 1, 0);         // enable mid-frame ignored
        run_case("R1", 1500, 1530, 1, 0, -1, 1, 1);    // max length stripped
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule